// File: doc/BRIEF.md
# Vector-Started Program Counter

This block keeps the 16-bit instruction address of a small byte-oriented processor. It does not leave reset at a fixed value. It first reads its starting address from the two lowest memory bytes, one byte per cycle, over a byte-wide read port. Only then does it report that it is ready.

Once ready, the counter moves forward by the byte length of each fetched instruction when the advance strobe is raised. When the branch-load port is raised, it takes a 16-bit target instead. The decoder and the memory sit outside this block. A generic load port is the only route for jumps, calls and returns.

The memory read is combinational: `vec_data` must carry the byte at `vec_addr` in the same cycle that `vec_rd` is high.

Top module: `pc_vector_unit`

## Requirements
- R1: In the first cycle after reset is released, `vec_rd` is 1, `vec_addr` is 0000H and `ready` is 0.
- R2: In the second cycle after reset release, `vec_rd` is 1, `vec_addr` is 0001H and `ready` is still 0.
- R3: From the third cycle on, `ready` is 1 and stays 1. `pc` then holds the vector: bits 7:0 come from the byte read at 0000H and bits 15:8 from the byte read at 0001H.
- R4: While `ready` is 0, `adv` and `br_ld` have no effect: the `pc` seen when `ready` rises is the vector, whatever those inputs did during the fetch.
- R5: When `ready` is 1, `adv` is 1 and `br_ld` is 0, `pc` becomes `pc + ilen` on the next cycle. `ilen` is an unsigned count of 1 to 4 bytes.
- R6: The increment wraps modulo 2^16; for example, FFFEH advanced by 4 gives 0002H.
- R7: When `ready` is 1 and `br_ld` is 1, `pc` becomes `br_tgt` on the next cycle.
- R8: If `br_ld` and `adv` are both 1 in the same cycle, the branch target is taken and the length is ignored.
- R9: When `ready` is 1 and neither `adv` nor `br_ld` is set, `pc` keeps its value.
- R10: `vec_rd` is 0 whenever `ready` is 1.
- R11: `rst_n` low clears `ready` and `pc` at once, without waiting for a clock edge. The next release repeats the two-byte vector fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_rd | output | 1 | Read strobe for the vector fetch |
| vec_addr | output | 16 | Address of the vector byte being read |
| vec_data | input | 8 | Byte returned from `vec_addr` in the same cycle |
| adv | input | 1 | Advance by `ilen` bytes |
| ilen | input | 3 | Instruction length, 1 to 4 |
| br_ld | input | 1 | Load `br_tgt` into the counter |
| br_tgt | input | 16 | Branch or load target |
| pc | output | 16 | Current program counter |
| ready | output | 1 | Vector fetch complete, counter running |

## Verification
The bench raises `adv` and `br_ld` with unusual values during both fetch cycles. A design that lets them through would show a vector that differs from the one in memory when `ready` rises. It places distinct bytes at 0000H and 0001H, so a swapped byte order shows up as a reversed `pc`. It branches to FFFEH and then advances past the top of the address space, which catches an adder that saturates or carries into a wider result. It also raises both strobes together, which exposes a design that gives the length priority over the target. A reset in the middle of a run must return the block to the fetch sequence with a new vector; a design that skips the refetch or keeps stale bytes fails this check.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
   typedef enum logic {PH_FETCH = 1'b0, PH_RUN = 1'b1} pcu_phase_t;

   function automatic int unsigned lanes_of(input int unsigned width);
      return width / 8;
   endfunction
endpackage

// File: rtl/pcu_vec_seq.sv
module pcu_vec_seq #(
   parameter int unsigned AW       = 16,
   parameter logic [AW-1:0] VEC_BASE = '0,
   localparam int unsigned NLANE   = pcu_pkg::lanes_of(AW),
   localparam int unsigned CW      = (NLANE > 1) ? $clog2(NLANE) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic             rd,
   output logic [AW-1:0]    addr,
   output logic [NLANE-1:0] lane_we,
   output logic             run
);
   import pcu_pkg::*;

   pcu_phase_t    phase_q;
   logic [CW-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_FETCH;
         idx_q   <= '0;
      end else if (phase_q == PH_FETCH) begin
         if (idx_q == CW'(NLANE - 1)) phase_q <= PH_RUN;
         else                         idx_q   <= idx_q + 1'b1;
      end
   end

   always_comb begin
      rd      = (phase_q == PH_FETCH);
      run     = (phase_q == PH_RUN);
      addr    = VEC_BASE + AW'(idx_q);
      lane_we = '0;
      if (rd) lane_we[idx_q] = 1'b1;
   end

   p_one_lane_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_we));
   p_run_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      run |=> run);
   p_no_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> !rd);
endmodule

// File: rtl/pcu_pc_reg.sv
module pcu_pc_reg #(
   parameter int unsigned AW     = 16,
   parameter int unsigned MAXLEN = 4,
   localparam int unsigned NLANE = pcu_pkg::lanes_of(AW),
   localparam int unsigned LW    = $clog2(MAXLEN + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NLANE-1:0] lane_we,
   input  logic [7:0]       byte_in,
   input  logic             run,
   input  logic             adv,
   input  logic [LW-1:0]    len,
   input  logic             load,
   input  logic [AW-1:0]    target,
   output logic [AW-1:0]    pc
);
   logic [AW-1:0] pc_n;

   // A load has priority over an advance (R8).
   always_comb begin
      pc_n = pc;
      if (run) begin
         if (load)     pc_n = target;
         else if (adv) pc_n = pc + AW'(len);
      end
   end

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          pc[g*8 +: 8] <= 8'h00;
         else if (lane_we[g]) pc[g*8 +: 8] <= byte_in;
         else if (run)        pc[g*8 +: 8] <= pc_n[g*8 +: 8];
      end
   end

   p_len_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && adv && !load) |-> (len >= 1 && len <= LW'(MAXLEN)));
   p_adv_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && adv && !load) |=> pc == $past(pc) + AW'($past(len)));
   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && load) |=> pc == $past(target));
   p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !adv && !load) |=> $stable(pc));
endmodule

// File: rtl/pc_vector_unit.sv
module pc_vector_unit #(
   parameter int unsigned   AW       = 16,
   parameter int unsigned   MAXLEN   = 4,
   parameter logic [AW-1:0] VEC_BASE = '0,
   localparam int unsigned  LW       = $clog2(MAXLEN + 1),
   localparam int unsigned  NLANE    = pcu_pkg::lanes_of(AW)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic          vec_rd,
   output logic [AW-1:0] vec_addr,
   input  logic [7:0]    vec_data,
   input  logic          adv,
   input  logic [LW-1:0] ilen,
   input  logic          br_ld,
   input  logic [AW-1:0] br_tgt,
   output logic [AW-1:0] pc,
   output logic          ready
);
   if (AW % 8 != 0 || AW < 16) begin : g_bad_width
      $error("pc_vector_unit: AW must be a multiple of 8, at least 16");
   end
   if (MAXLEN < 1) begin : g_bad_len
      $error("pc_vector_unit: MAXLEN must be at least 1");
   end

   logic [NLANE-1:0] lane_we;

   pcu_vec_seq #(.AW(AW), .VEC_BASE(VEC_BASE)) u_seq (
      .clk(clk), .rst_n(rst_n), .rd(vec_rd), .addr(vec_addr),
      .lane_we(lane_we), .run(ready)
   );

   pcu_pc_reg #(.AW(AW), .MAXLEN(MAXLEN)) u_pc (
      .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .byte_in(vec_data),
      .run(ready), .adv(adv), .len(ilen), .load(br_ld), .target(br_tgt),
      .pc(pc)
   );

   p_last_byte_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(vec_addr) == VEC_BASE + AW'(NLANE - 1));
   p_fetch_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !vec_rd) |-> 1'b0);
endmodule

// File: tb/pc_vector_unit_tb.sv
module pc_vector_unit_tb;
   localparam int CLK_NS = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        vec_rd, ready;
   logic [15:0] vec_addr, pc, br_tgt;
   logic [7:0]  vec_data;
   logic        adv, br_ld;
   logic [2:0]  ilen;
   logic [7:0]  mem0, mem1;
   int          n_chk = 0, n_bad = 0;
   bit          done = 0;
   logic [15:0] exp_pc;

   always #(CLK_NS/2) clk = ~clk;

   pc_vector_unit u_dut (
      .clk(clk), .rst_n(rst_n), .vec_rd(vec_rd), .vec_addr(vec_addr),
      .vec_data(vec_data), .adv(adv), .ilen(ilen), .br_ld(br_ld),
      .br_tgt(br_tgt), .pc(pc), .ready(ready)
   );

   assign vec_data = (vec_addr == 16'h0000) ? mem0 :
                     (vec_addr == 16'h0001) ? mem1 : 8'hEE;

   function automatic logic [15:0] model(input logic [15:0] cur, input logic a,
                                         input logic [2:0] l, input logic b,
                                         input logic [15:0] t);
      if (b) return t;
      if (a) return cur + 16'(l);
      return cur;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic step(input logic a, input logic [2:0] l, input logic b,
                       input logic [15:0] t, input string req);
      adv = a; ilen = l; br_ld = b; br_tgt = t;
      exp_pc = model(exp_pc, a, l, b, t);
      @(posedge clk); @(negedge clk);
      chk(req, pc, exp_pc);
   endtask

   task automatic fetch(input logic [7:0] b0, input logic [7:0] b1);
      mem0 = b0; mem1 = b1;
      adv = 1'b1; ilen = 3'd3; br_ld = 1'b1; br_tgt = 16'hDEAD;
      @(negedge clk); rst_n = 1'b1; #1;
      chk("R1 rd", vec_rd, 1); chk("R1 addr", vec_addr, 16'h0000); chk("R1 ready", ready, 0);
      @(negedge clk);
      chk("R2 rd", vec_rd, 1); chk("R2 addr", vec_addr, 16'h0001); chk("R2 ready", ready, 0);
      br_tgt = 16'hBEEF; ilen = 3'd4;
      @(negedge clk);
      chk("R3 ready", ready, 1);
      chk("R3 R4 vector", pc, {b1, b0});
      chk("R10 rd", vec_rd, 0);
      exp_pc = {b1, b0};
      adv = 1'b0; br_ld = 1'b0;
   endtask

   initial begin
      #(CLK_NS * 150000);
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finish");
      if (!done) $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      adv = 0; br_ld = 0; ilen = 1; br_tgt = 0; mem0 = 0; mem1 = 0; exp_pc = 0;
      repeat (3) @(negedge clk);
      chk("R11 reset ready", ready, 0);
      chk("R11 reset pc", pc, 0);
      fetch(8'h34, 8'h12);
      step(0, 3'd2, 0, 16'h0, "R9 hold");
      step(1, 3'd1, 0, 16'h0, "R5 len1");
      step(1, 3'd4, 0, 16'h0, "R5 len4");
      step(0, 3'd1, 1, 16'hFFFE, "R7 branch");
      step(1, 3'd4, 0, 16'h0, "R6 wrap");
      step(1, 3'd2, 1, 16'h4000, "R8 both");
      for (int i = 0; i < 400; i++) begin
         logic a, b; logic [2:0] l; logic [15:0] t;
         a = $urandom_range(0, 1) == 1;
         b = $urandom_range(0, 7) == 0;
         l = 3'($urandom_range(1, 4));
         t = ($urandom_range(0, 3) == 0) ? 16'hFFFC : 16'($urandom);
         step(a, l, b, t, "R5 R7 R8 R9 random");
         chk("R10 running", vec_rd, 0);
      end
      @(negedge clk); #2;
      rst_n = 1'b0; #1;
      chk("R11 async ready", ready, 0);
      chk("R11 async pc", pc, 0);
      @(negedge clk);
      fetch(8'hA5, 8'h5A);
      step(1, 3'd3, 0, 16'h0, "R5 after refetch");
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule